// File: doc/BRIEF.md
# QPSK Correlation Demodulator

This block turns a stream of 8-bit signed carrier samples back into data bytes. Each symbol lasts a fixed number of samples. An external strobe marks the first sample of every symbol. The demodulator correlates the received samples against four stored reference waveforms in four parallel multiply-accumulate lanes:

| Code | Reference |
|------|-----------|
| 00 | sine |
| 01 | cosine |
| 10 | negated sine |
| 11 | negated cosine |

When the symbol ends, a comparator picks the lane with the largest sum. That lane's code is the decoded symbol.

Decoded symbols are gathered four at a time into an output byte, and a single-cycle strobe flags each completed byte. The block sits after a matching modulator, or in a loopback with one. It does not recover carrier phase or timing, does not filter noise and does not despread.

Top module: `qpsk_corr_demod`

## Requirements
- R1: While reset is high and after it falls, `sym_valid` and `byte_valid` are 0 and `byte_out` is 8'h00.
- R2: Each accepted sample is multiplied by the reference sample of the same index within the symbol. Index 0 is the sample presented with `sym_start`. The references by code are: 00 sine, 01 cosine, 10 negated sine, 11 negated cosine.
- R3: The accumulators are wide enough that full-scale sample patterns (+127/−128 square waves) over a whole symbol never wrap, so such symbols still decode correctly.
- R4: `sym_valid` is a one-cycle pulse. It rises in the second cycle after the clock edge that accepts the last sample of a symbol, never earlier. `sym_code` is valid during that pulse.
- R5: When two or more correlation sums are equal, the lowest code among the tied largest sums is chosen. An all-zero symbol decodes to 00.
- R6: The k-th symbol (k = 0..3) of each group of four goes to `byte_out[2k+1:2k]`. `byte_valid` pulses for one cycle, one clock after the fourth `sym_valid`, together with the new `byte_out`.
- R7: Samples presented with `sample_valid` high but outside any symbol, meaning after a symbol has completed and without `sym_start`, are ignored. They produce no `sym_valid`.
- R8: A `sym_start` in the middle of a symbol discards the partial sums and starts a new symbol with that sample as index 0.
- R9: With a matching modulator in loopback, every transmitted byte is recovered exactly.
- R10: Cycles with `sample_valid` low inside a symbol neither advance the sample index nor change the sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A sample is present on `sample` |
| sym_start | input | 1 | Current sample is the first of a symbol |
| sample | input | 8 | Signed received sample |
| sym_valid | output | 1 | One-cycle strobe for a decoded symbol |
| sym_code | output | 2 | Decoded symbol code |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_out | output | 8 | Last completed byte |

## Verification
The bench stresses the accumulator width with full-scale square waves. A narrow accumulator would wrap and report the wrong phase on those symbols.

An all-zero symbol ties all four sums. A comparator with the wrong tie order would return a nonzero code.

Stray samples after a symbol, a restart halfway through a symbol, and idle gaps inside a symbol are also driven. A design that mishandles them would emit spurious decisions, blend two symbols, or skip reference indices. The decision and byte strobes are timed to the exact cycle, so an added or missing register stage is reported.

// File: rtl/qpsk_demod_pkg.sv
package qpsk_demod_pkg;

    typedef enum logic [1:0] {
        SYM_SIN  = 2'b00,
        SYM_COS  = 2'b01,
        SYM_NSIN = 2'b10,
        SYM_NCOS = 2'b11
    } sym_code_e;

    typedef struct packed {
        logic      valid;
        sym_code_e code;
    } decision_t;

    localparam int NUM_LANES = 4;

    // Integer sine approximation (rational form), amplitude amp, period sps.
    // Lane offsets: code c uses the sine shifted by c quarter periods.
    function automatic int ref_val(input int lane, input int k, input int sps, input int amp);
        int p;
        int x;
        int t;
        int v;
        bit neg;
        p   = (k + lane * (sps / 4)) % sps;
        x   = (360 * p) / sps;
        neg = (x >= 180);
        if (neg) x = x - 180;
        t = x * (180 - x);
        v = (4 * t * amp + (40500 - t) / 2) / (40500 - t);
        return neg ? -v : v;
    endfunction

endpackage

// File: rtl/corr_lane.sv
module corr_lane
    import qpsk_demod_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int SAMP_W = 8,
    parameter int SPS    = 16,
    parameter int ACC_W  = 20,
    localparam int IDX_W = $clog2(SPS),
    localparam int PROD_W = 2 * SAMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mac_en,
    input  logic                     clear_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic signed [SAMP_W-1:0] sample,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int AMP = (1 << (SAMP_W - 1)) - 1;

    logic signed [SAMP_W-1:0] ref_tab [SPS];

    for (genvar g = 0; g < SPS; g++) begin : g_ref
        assign ref_tab[g] = SAMP_W'(ref_val(LANE, g, SPS, AMP));
    end

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W:0]    prod_ext;
    logic signed [ACC_W:0]    wide_sum;
    logic signed [ACC_W-1:0]  acc_q;

    always_comb begin
        prod     = sample * ref_tab[idx];
        prod_ext = {{(ACC_W + 1 - PROD_W){prod[PROD_W-1]}}, prod};
        wide_sum = {acc_q[ACC_W-1], acc_q} + prod_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (mac_en) begin
            if (clear_en) acc_q <= prod_ext[ACC_W-1:0];
            else          acc_q <= wide_sum[ACC_W-1:0];
        end
    end

    assign acc = acc_q;

    // R3: the running sum must never need the guard bit
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (mac_en && !clear_en) |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

endmodule

// File: rtl/corr_picker.sv
module corr_picker
    import qpsk_demod_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          decide,
    input  logic [NUM_LANES*ACC_W-1:0]    sums_flat,
    output decision_t                     dec
);
    logic signed [ACC_W-1:0] sum_a [NUM_LANES];
    logic [1:0]              best;

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_unpack
        assign sum_a[j] = sums_flat[j*ACC_W +: ACC_W];
    end

    // Strict greater-than scan from code 0 upward: ties keep the lower code.
    always_comb begin
        best = 2'd0;
        for (int j = 1; j < NUM_LANES; j++) begin
            if (sum_a[j] > sum_a[best]) best = 2'(j);
        end
    end

    decision_t dec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q.valid <= decide;
            if (decide) dec_q.code <= sym_code_e'(best);
        end
    end

    assign dec = dec_q;

    // R5: the chosen sum beats every lower code strictly, every higher code or equal
    for (genvar c = 0; c < NUM_LANES; c++) begin : g_chk_c
        for (genvar j = 0; j < NUM_LANES; j++) begin : g_chk_j
            if (j < c) begin : g_lo
                assert_pick_lower_R5: assert property (@(posedge clk) disable iff (rst)
                    (dec_q.valid && dec_q.code == sym_code_e'(c)) |->
                        ($past(sum_a[c]) > $past(sum_a[j])));
            end else if (j > c) begin : g_hi
                assert_pick_higher_R5: assert property (@(posedge clk) disable iff (rst)
                    (dec_q.valid && dec_q.code == sym_code_e'(c)) |->
                        ($past(sum_a[c]) >= $past(sum_a[j])));
            end
        end
    end

endmodule

// File: rtl/pair_packer.sv
module pair_packer
    import qpsk_demod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output logic      byte_valid,
    output logic [7:0] byte_out
);
    logic [1:0] slot_q;
    logic [7:0] build_q;
    logic [7:0] build_nx;
    logic       bv_q;
    logic [7:0] bo_q;

    always_comb begin
        build_nx = build_q;
        build_nx[2*slot_q +: 2] = dec.code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            build_q <= '0;
            bv_q    <= 1'b0;
            bo_q    <= '0;
        end else begin
            bv_q <= 1'b0;
            if (dec.valid) begin
                build_q <= build_nx;
                slot_q  <= slot_q + 2'd1;
                if (slot_q == 2'd3) begin
                    bv_q <= 1'b1;
                    bo_q <= build_nx;
                end
            end
        end
    end

    assign byte_valid = bv_q;
    assign byte_out   = bo_q;

    assert_byte_after_sym_R6: assert property (@(posedge clk) disable iff (rst)
        bv_q |-> $past(dec.valid));
    assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        bv_q |=> !bv_q);

endmodule

// File: rtl/qpsk_corr_demod.sv
module qpsk_corr_demod
    import qpsk_demod_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int SPS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic              sym_start,
    input  logic [SAMP_W-1:0] sample,
    output logic              sym_valid,
    output logic [1:0]        sym_code,
    output logic              byte_valid,
    output logic [7:0]        byte_out
);
    localparam int IDX_W = $clog2(SPS);
    localparam int CNT_W = $clog2(SPS + 1);
    localparam int ACC_W = 2 * SAMP_W + IDX_W;
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(SPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx;
    logic             take;
    logic             last;
    logic             done_q;

    // A sample counts if it opens a symbol or falls inside one that is running.
    always_comb begin
        take = sample_valid && (sym_start || cnt_q != IDLE);
        idx  = sym_start ? '0 : cnt_q;
        last = take && (idx == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (take) cnt_q <= idx + CNT_W'(1);
        end
    end

    logic [NUM_LANES*ACC_W-1:0] sums_flat;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        corr_lane #(
            .LANE  (l),
            .SAMP_W(SAMP_W),
            .SPS   (SPS),
            .ACC_W (ACC_W)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .mac_en  (take),
            .clear_en(sym_start),
            .idx     (idx[IDX_W-1:0]),
            .sample  (sample),
            .acc     (sums_flat[l*ACC_W +: ACC_W])
        );
    end

    decision_t dec;

    corr_picker #(.ACC_W(ACC_W)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .decide   (done_q),
        .sums_flat(sums_flat),
        .dec      (dec)
    );

    pair_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .byte_valid(byte_valid),
        .byte_out  (byte_out)
    );

    assign sym_valid = dec.valid;
    assign sym_code  = dec.code;

    // R4: decision appears two edges after the last sample is taken
    assert_decide_timing_R4: assert property (@(posedge clk) disable iff (rst)
        last |-> ##2 sym_valid);
    assert_sym_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);
    // R7: stray samples outside a symbol leave the counter parked
    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && !sym_start && cnt_q == IDLE) |=> (cnt_q == IDLE));
    // R10: an idle cycle inside a symbol holds the index
    assert_gap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid) |=> $stable(cnt_q));

endmodule

// File: tb/qpsk_corr_demod_test.sv
module qpsk_corr_demod_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  SPS = 16;
    localparam real PI  = 3.14159265358979;
    localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'hE4, 8'h1B, 8'hA5, 8'h5A, 8'h3C, 8'h96};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_valid = 1'b0;
    logic       sym_start = 1'b0;
    logic [7:0] sample = '0;
    logic       sym_valid;
    logic [1:0] sym_code;
    logic       byte_valid;
    logic [7:0] byte_out;

    int checks = 0;
    int errors = 0;
    int slot_b = 0;
    logic [7:0] build_b = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qpsk_corr_demod uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sym_start(sym_start),
        .sample(sample), .sym_valid(sym_valid), .sym_code(sym_code),
        .byte_valid(byte_valid), .byte_out(byte_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // mode 0: clean waveform, 1: full-scale square, 2: all zero
    function automatic int samp(input int code, input int mode, input int k);
        real s;
        s = $sin(2.0 * PI * k / SPS + code * PI / 2.0);
        if (mode == 2) return 0;
        if (mode == 1) return (s > 0.001) ? 127 : ((s < -0.001) ? -128 : 0);
        return (s >= 0.0) ? $rtoi(127.0 * s + 0.5) : -$rtoi(-127.0 * s + 0.5);
    endfunction

    task automatic send_sym(input int code, input int mode, input bit gaps, input string tag);
        int exp_code;
        exp_code = (mode == 2) ? 0 : code;
        for (int k = 0; k < SPS; k++) begin
            sample_valid = 1'b1;
            sym_start    = (k == 0);
            sample       = 8'(samp(code, mode, k));
            @(negedge clk);
            if (gaps && (k == 4 || k == 9)) begin
                sample_valid = 1'b0;
                sym_start    = 1'b0;
                sample       = 8'h55;
                @(negedge clk);
                @(negedge clk);
            end
        end
        sample_valid = 1'b0;
        sym_start    = 1'b0;
        check(sym_valid == 1'b0, "R4 early strobe", int'(sym_valid), 0);
        @(negedge clk);
        check(sym_valid == 1'b1, "R4 strobe cycle", int'(sym_valid), 1);
        check(sym_code == 2'(exp_code), tag, int'(sym_code), exp_code);
        build_b[2*slot_b +: 2] = sym_code;
        @(negedge clk);
        check(sym_valid == 1'b0, "R4 strobe width", int'(sym_valid), 0);
        if (slot_b == 3) begin
            check(byte_valid == 1'b1, "R6 byte strobe", int'(byte_valid), 1);
            check(byte_out == build_b, "R6 byte packing", int'(byte_out), int'(build_b));
        end else begin
            check(byte_valid == 1'b0, "R6 no early byte", int'(byte_valid), 0);
        end
        slot_b = (slot_b + 1) % 4;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(sym_valid == 0 && byte_valid == 0, "R1 strobes in reset", int'(sym_valid), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sym_valid == 0 && byte_valid == 0, "R1 strobes after reset", int'(byte_valid), 0);
        check(byte_out == 8'h00, "R1 byte reset value", int'(byte_out), 0);

        // R9 / R2: loopback of the vector table, pairs 0..3 in order
        for (int v = 0; v < 8; v++) begin
            for (int p = 0; p < 4; p++)
                send_sym(int'(VEC[v][2*p +: 2]), 0, 1'b0, "R2 symbol decode");
            check(byte_out == VEC[v], "R9 loopback byte", int'(byte_out), int'(VEC[v]));
        end

        // R10: idle cycles inside a symbol
        send_sym(2, 0, 1'b1, "R10 gaps inside symbol");
        send_sym(1, 0, 1'b1, "R10 gaps inside symbol");
        // R3: full-scale square waves
        send_sym(0, 1, 1'b0, "R3 full scale sine");
        send_sym(2, 1, 1'b0, "R3 full scale neg sine");
        // R5: all-zero ties to code 00
        send_sym(3, 2, 1'b0, "R5 tie lowest code");

        // R8: half symbol of code 3, then restart with code 1
        for (int k = 0; k < SPS / 2; k++) begin
            sample_valid = 1'b1;
            sym_start    = (k == 0);
            sample       = 8'(samp(3, 0, k));
            @(negedge clk);
        end
        check(sym_valid == 1'b0, "R8 no strobe on partial", int'(sym_valid), 0);
        send_sym(1, 0, 1'b0, "R8 restart mid symbol");

        // R7: stray samples after a completed symbol
        for (int k = 0; k < SPS + 3; k++) begin
            sample_valid = (k < SPS);
            sym_start    = 1'b0;
            sample       = 8'(samp(0, 1, k));
            @(negedge clk);
            check(sym_valid == 1'b0, "R7 stray samples ignored", int'(sym_valid), 0);
        end
        sample_valid = 1'b0;
        send_sym(3, 0, 1'b0, "R7 decode after stray samples");
        send_sym(0, 0, 1'b0, "R2 symbol decode");
        send_sym(2, 0, 1'b0, "R2 symbol decode");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule